// File: doc/BRIEF.md
# Speculative Flit Classifier for a Preferred-Path Mesh Router

This unit sits on one input of a five-port mesh router. In that router an output port can be statically wired to one preferred input. A flit that arrives on that input goes out through the pre-enabled connection at once, before any routing decision has been made. The unit looks at each arriving flit and asks three questions. Did one of those eager copies actually move the packet toward its destination? Are the eager copies all useless, so that they will be discarded downstream? Must the flit also be written into the local input FIFO so that ordinary dimension-order switching can deliver it?

An eager copy is useful when the output it left by brings the packet closer to its destination along either axis. The order in which a strict dimension-order route would take the axes does not matter. Only the head flit carries a destination. The unit stores the head's verdict and gives the same answer for every later flit of that packet until the flit that closes it. Because eager copies may stray from the dimension-order route, the network downstream must accept duplicate deliveries. This unit only classifies flits; it does not filter duplicates.

All outputs are combinational in the cycle the flit is valid. Only the per-packet memory is clocked.

Top module: `sfr_classify_unit`

## Requirements
- R1: While `flit_valid` is low, `dead`, `enq_req` and `port_req` are all 0, including directly after reset.
- R2: A head flit whose destination equals (`local_x`, `local_y`) is never dead and requests port 0 (local). `enq_req` is 0 when the local output's preferred input is this input, and 1 otherwise.
- R3: Port codes are 0 local, 1 north (Y+1), 2 east (X+1), 3 south (Y-1), 4 west (X-1). The dimension-order port moves along X first and along Y only when X already matches.
- R4: When at least one eager output of a non-local head brings the destination closer in X or in Y, the unit gives `dead`=0 and `enq_req`=0. `port_req` is the dimension-order port if that port is one of the useful eager outputs; otherwise it is the other useful eager output.
- R5: When a non-local head has eager outputs and none of them brings the destination closer, the unit gives `dead`=1, `enq_req`=1 and the dimension-order port.
- R6: A non-local head with no eager output gives `dead`=0, `enq_req`=1 and the dimension-order port.
- R7: Flits with bit 38 = 0 that arrive while a packet is open repeat the head's `dead`, `enq_req` and `port_req` exactly. This holds even if the preferred map or the local coordinates change in the meantime.
- R8: A flit with bit 37 (tail) = 1 and bit 38 = 0 closes the packet. A flit without bit 38 that arrives while no packet is open is dropped: `dead`=1, `enq_req`=0, `port_req`=0.
- R9: A head flit with bit 37 also set is a whole packet by itself and opens no packet. Reset also leaves no packet open.
- R10: Flit format: bit 38 is the head marker, bit 37 the tail marker, bits 5:3 the destination X and bits 2:0 the destination Y.
- R11: `pref_sel` holds one 3-bit field per output port, at bits [3*o+2:3*o] for port o. Output o is eager for this input only when its field equals parameter `MY_PORT` (default 1). Field values 5 to 7 mean unassigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flit_in | input | 39 | Arriving flit |
| flit_valid | input | 1 | Flit present this cycle |
| local_x | input | 3 | This router's X coordinate |
| local_y | input | 3 | This router's Y coordinate |
| pref_sel | input | 15 | Preferred input index for each output port |
| dead | output | 1 | Every eager copy of this flit is useless or dropped |
| enq_req | output | 1 | Write the flit into the local input FIFO |
| port_req | output | 3 | Output port for this flit |

## Verification
Head flits are sent toward all four compass directions and to the home node, so the dimension-order choice can be told apart from the local case. For one fixed destination, the preferred map is then varied between no eager output, an eager output on the Y axis only, an eager output on the X axis plus one on the Y axis, and eager outputs that point away. This separates the "closer in either axis" rule from a strict X-first rule and shows where the dead verdict sets in. Multi-flit packets are sent with the map changed between head and body, followed by a stray body flit, a single-flit packet and a reset in mid-packet. These show that the verdict is held per packet and released only at the right moments.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  localparam int unsigned NUM_PORTS = 5;
  localparam int unsigned CW_MAX    = 8;

  typedef logic [CW_MAX-1:0] coord_t;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_NORTH = 3'd1,
    PORT_EAST  = 3'd2,
    PORT_SOUTH = 3'd3,
    PORT_WEST  = 3'd4
  } port_e;

  typedef struct packed {
    logic  dead;
    logic  enq;
    port_e port;
  } verdict_t;

  // Outputs that shorten the distance to the target; bit 0 marks arrival.
  function automatic logic [NUM_PORTS-1:0] gain_mask(coord_t hx, coord_t hy,
                                                     coord_t tx, coord_t ty);
    logic [NUM_PORTS-1:0] m;
    m = '0;
    m[PORT_EAST]  = (tx > hx);
    m[PORT_WEST]  = (tx < hx);
    m[PORT_NORTH] = (ty > hy);
    m[PORT_SOUTH] = (ty < hy);
    m[PORT_LOCAL] = (tx == hx) && (ty == hy);
    return m;
  endfunction

  // Dimension-order step: X first, then Y.
  function automatic port_e xy_step(coord_t hx, coord_t hy,
                                    coord_t tx, coord_t ty);
    if (tx > hx)      return PORT_EAST;
    else if (tx < hx) return PORT_WEST;
    else if (ty > hy) return PORT_NORTH;
    else if (ty < hy) return PORT_SOUTH;
    else              return PORT_LOCAL;
  endfunction

endpackage

// File: rtl/sfr_eager_mask.sv
module sfr_eager_mask #(
  parameter int unsigned NPORTS  = 5,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned MY_PORT = 1
) (
  input  logic [NPORTS*SEL_W-1:0] pref_sel,
  output logic [NPORTS-1:0]       eager
);

  localparam logic [SEL_W-1:0] SELF_ID = SEL_W'(MY_PORT);

  for (genvar o = 0; o < NPORTS; o++) begin : g_out
    assign eager[o] = (pref_sel[o*SEL_W +: SEL_W] == SELF_ID);
  end

endmodule

// File: rtl/sfr_head_decide.sv
module sfr_head_decide
  import sfr_pkg::*;
#(
  parameter int unsigned NPORTS = NUM_PORTS
) (
  input  coord_t              here_x,
  input  coord_t              here_y,
  input  coord_t              dest_x,
  input  coord_t              dest_y,
  input  logic [NPORTS-1:0]   eager,
  output verdict_t            verdict,
  output logic                home_hit,
  output logic                useful_any,
  output logic                all_wasted
);

  logic [NPORTS-1:0] gain;
  logic [NPORTS-1:0] useful;
  port_e             xy_port;
  port_e             alt_port;

  always_comb begin
    gain     = gain_mask(here_x, here_y, dest_x, dest_y);
    xy_port  = xy_step(here_x, here_y, dest_x, dest_y);
    useful   = gain & eager;
    useful[PORT_LOCAL] = 1'b0;
    alt_port = PORT_LOCAL;
    for (int p = NPORTS - 1; p >= 0; p--) begin
      if (useful[p]) alt_port = port_e'(p);
    end
  end

  assign home_hit   = gain[PORT_LOCAL];
  assign useful_any = |useful;
  assign all_wasted = !home_hit && !useful_any && (|eager);

  always_comb begin
    verdict.dead = 1'b0;
    verdict.enq  = 1'b1;
    verdict.port = xy_port;
    if (home_hit) begin
      verdict.port = PORT_LOCAL;
      verdict.enq  = !eager[PORT_LOCAL];
    end else if (useful_any) begin
      verdict.enq  = 1'b0;
      verdict.port = useful[xy_port] ? xy_port : alt_port;
    end else begin
      verdict.dead = all_wasted;
    end
  end

endmodule

// File: rtl/sfr_pkt_track.sv
module sfr_pkt_track
  import sfr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     flit_valid,
  input  logic     is_head,
  input  logic     is_tail,
  input  verdict_t head_verdict,
  output logic     pkt_open,
  output verdict_t held
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_open <= 1'b0;
      held     <= '0;
    end else if (flit_valid) begin
      if (is_head) begin
        pkt_open <= !is_tail;
        held     <= head_verdict;
      end else if (is_tail) begin
        pkt_open <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sfr_classify_unit.sv
module sfr_classify_unit
  import sfr_pkg::*;
#(
  parameter int unsigned FLIT_W  = 39,
  parameter int unsigned COORD_W = 3,
  parameter int unsigned NPORTS  = NUM_PORTS,
  parameter int unsigned MY_PORT = 1,
  localparam int unsigned PORT_W = $clog2(NPORTS),
  localparam int unsigned SEL_W  = PORT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [FLIT_W-1:0]       flit_in,
  input  logic                    flit_valid,
  input  logic [COORD_W-1:0]      local_x,
  input  logic [COORD_W-1:0]      local_y,
  input  logic [NPORTS*SEL_W-1:0] pref_sel,
  output logic                    dead,
  output logic                    enq_req,
  output logic [PORT_W-1:0]       port_req
);

  localparam int unsigned HEAD_BIT = FLIT_W - 1;
  localparam int unsigned TAIL_BIT = FLIT_W - 2;
  localparam int unsigned DX_LO    = COORD_W;
  localparam int unsigned DY_LO    = 0;

  logic              is_head;
  logic              is_tail;
  logic [NPORTS-1:0] eager;
  coord_t            here_x, here_y, dest_x, dest_y;
  verdict_t          head_verdict;
  verdict_t          held;
  verdict_t          out_v;
  logic              pkt_open;
  logic              home_hit;
  logic              useful_any;
  logic              all_wasted;
  logic              stray_body;

  assign is_head = flit_in[HEAD_BIT];
  assign is_tail = flit_in[TAIL_BIT];
  assign here_x  = coord_t'(local_x);
  assign here_y  = coord_t'(local_y);
  assign dest_x  = coord_t'(flit_in[DX_LO +: COORD_W]);
  assign dest_y  = coord_t'(flit_in[DY_LO +: COORD_W]);

  sfr_eager_mask #(
    .NPORTS (NPORTS),
    .SEL_W  (SEL_W),
    .MY_PORT(MY_PORT)
  ) u_eager (
    .pref_sel(pref_sel),
    .eager   (eager)
  );

  sfr_head_decide #(
    .NPORTS(NPORTS)
  ) u_decide (
    .here_x    (here_x),
    .here_y    (here_y),
    .dest_x    (dest_x),
    .dest_y    (dest_y),
    .eager     (eager),
    .verdict   (head_verdict),
    .home_hit  (home_hit),
    .useful_any(useful_any),
    .all_wasted(all_wasted)
  );

  sfr_pkt_track u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .flit_valid  (flit_valid),
    .is_head     (is_head),
    .is_tail     (is_tail),
    .head_verdict(head_verdict),
    .pkt_open    (pkt_open),
    .held        (held)
  );

  assign stray_body = flit_valid && !is_head && !pkt_open;

  always_comb begin
    out_v = '0;
    if (flit_valid) begin
      if (is_head)       out_v = head_verdict;
      else if (pkt_open) out_v = held;
      else begin
        out_v.dead = 1'b1;
        out_v.enq  = 1'b0;
        out_v.port = PORT_LOCAL;
      end
    end
  end

  assign dead     = out_v.dead;
  assign enq_req  = out_v.enq;
  assign port_req = PORT_W'(out_v.port);

endmodule

// File: rtl/sfr_classify_checker.sv
module sfr_classify_checker #(
  parameter int unsigned FLIT_W  = 39,
  parameter int unsigned COORD_W = 3,
  parameter int unsigned NPORTS  = 5,
  parameter int unsigned PORT_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [FLIT_W-1:0]  flit_in,
  input logic               flit_valid,
  input logic [COORD_W-1:0] local_x,
  input logic [COORD_W-1:0] local_y,
  input logic               dead,
  input logic               enq_req,
  input logic [PORT_W-1:0]  port_req,
  input logic               home_hit,
  input logic               stray_body
);

  logic              c_head, c_tail, c_home;
  logic              sh_open;
  logic [PORT_W+1:0] sh_out;

  assign c_head = flit_in[FLIT_W-1];
  assign c_tail = flit_in[FLIT_W-2];
  assign c_home = (flit_in[COORD_W +: COORD_W] == local_x) &&
                  (flit_in[0 +: COORD_W] == local_y);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_open <= 1'b0;
      sh_out  <= '0;
    end else if (flit_valid) begin
      if (c_head) begin
        sh_open <= !c_tail;
        sh_out  <= {dead, enq_req, port_req};
      end else if (c_tail) begin
        sh_open <= 1'b0;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !flit_valid |-> (!dead && !enq_req && port_req == '0)); // R1
  AST_HOME_NOT_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid && c_head && c_home) |-> (!dead && port_req == '0 && home_hit)); // R2
  AST_PORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid |-> (port_req < PORT_W'(NPORTS))); // R3
  AST_SKIP_NOT_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid && c_head && !enq_req) |-> !dead); // R4
  AST_DEAD_ENQUEUES: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid && c_head && dead) |-> enq_req); // R5
  AST_BODY_INHERIT: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid && !c_head && sh_open) |-> ({dead, enq_req, port_req} == sh_out)); // R7
  AST_STRAY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid && !c_head && !sh_open) |-> (stray_body && dead && !enq_req)); // R8

endmodule

bind sfr_classify_unit sfr_classify_checker #(
  .FLIT_W (FLIT_W),
  .COORD_W(COORD_W),
  .NPORTS (NPORTS),
  .PORT_W (PORT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flit_in   (flit_in),
  .flit_valid(flit_valid),
  .local_x   (local_x),
  .local_y   (local_y),
  .dead      (dead),
  .enq_req   (enq_req),
  .port_req  (port_req),
  .home_hit  (home_hit),
  .stray_body(stray_body)
);

// File: tb/sfr_classify_unit_bench.sv
module sfr_classify_unit_bench;

  localparam int MY = 1;
  localparam logic [2:0] NO = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [38:0] flit_in = '0;
  logic        flit_valid = 1'b0;
  logic [2:0]  local_x = 3'd3;
  logic [2:0]  local_y = 3'd3;
  logic [14:0] pref_sel = {5{NO}};
  logic        dead;
  logic        enq_req;
  logic [2:0]  port_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sfr_classify_unit #(.MY_PORT(MY)) u_sfr_classify_unit (
    .clk(clk), .rst_n(rst_n), .flit_in(flit_in), .flit_valid(flit_valid),
    .local_x(local_x), .local_y(local_y), .pref_sel(pref_sel),
    .dead(dead), .enq_req(enq_req), .port_req(port_req)
  );

  // Field for output o picks that output's preferred input.
  function automatic logic [14:0] pmap(logic [2:0] f0, logic [2:0] f1,
                                       logic [2:0] f2, logic [2:0] f3,
                                       logic [2:0] f4);
    return {f4, f3, f2, f1, f0};
  endfunction

  // Independent model: {dead, enq, port}.
  function automatic logic [4:0] model(int hx, int hy, int tx, int ty,
                                       logic [14:0] pm);
    bit eg[5];
    int xdir, ydir, dor;
    bit any;
    any = 0;
    for (int o = 0; o < 5; o++) begin
      eg[o] = (pm[3*o +: 3] == 3'(MY));
      any |= eg[o];
    end
    if (tx == hx && ty == hy) return {1'b0, !eg[0], 3'd0};
    xdir = (tx > hx) ? 2 : (tx < hx) ? 4 : -1;
    ydir = (ty > hy) ? 1 : (ty < hy) ? 3 : -1;
    dor  = (xdir >= 0) ? xdir : ydir;
    if (xdir >= 0 && eg[xdir]) return {2'b00, 3'(xdir)};
    if (ydir >= 0 && eg[ydir]) return {2'b00, 3'(ydir)};
    return {any, 1'b1, 3'(dor)};
  endfunction

  task automatic chk(string req, logic ed, logic ee, logic [2:0] ep);
    checks++;
    if (dead !== ed || enq_req !== ee || port_req !== ep) begin
      errors++;
      $display("FAIL %s: got dead=%0b enq=%0b port=%0d, expected dead=%0b enq=%0b port=%0d",
               req, dead, enq_req, port_req, ed, ee, ep);
    end
  endtask

  task automatic send(bit hd, bit tl, int tx, int ty, logic [14:0] pm);
    @(negedge clk);
    pref_sel   = pm;
    flit_in    = {hd, tl, 31'h2A5C_3E71, 3'(tx), 3'(ty)};
    flit_valid = 1'b1;
    #1;
  endtask

  task automatic head_check(string req, int tx, int ty, logic [14:0] pm);
    logic [4:0] e;
    send(1'b1, 1'b1, tx, ty, pm);
    e = model(3, 3, tx, ty, pm);
    chk(req, e[4], e[3], e[2:0]);
  endtask

  task automatic go_idle();
    @(negedge clk);
    flit_valid = 1'b0;
    flit_in    = '1;
    #1;
  endtask

  task automatic t_idle();
    go_idle();
    chk("R1 idle after reset", 1'b0, 1'b0, 3'd0);
  endtask

  task automatic t_xy_plain();
    head_check("R3 R6 east", 5, 1, {5{NO}});
    head_check("R3 R6 west", 0, 3, {5{NO}});
    head_check("R3 R6 north", 3, 6, {5{NO}});
    head_check("R3 R6 south", 3, 0, {5{NO}});
    chk("R6 explicit south", 1'b0, 1'b1, 3'd3);
  endtask

  task automatic t_productive();
    head_check("R4 y-axis eager only", 5, 1, pmap(NO, NO, NO, 3'd1, NO));
    chk("R4 explicit", 1'b0, 1'b0, 3'd3);
    head_check("R4 xy port preferred", 5, 1, pmap(NO, NO, 3'd1, 3'd1, NO));
    chk("R4 explicit xy", 1'b0, 1'b0, 3'd2);
    head_check("R4 one useful one away", 5, 1, pmap(NO, 3'd1, NO, 3'd1, NO));
    head_check("R4 west", 1, 1, pmap(NO, 3'd1, NO, NO, 3'd1));
  endtask

  task automatic t_dead();
    head_check("R5 away north", 5, 1, pmap(NO, 3'd1, NO, NO, NO));
    chk("R5 explicit", 1'b1, 1'b1, 3'd2);
    head_check("R5 away north west", 5, 1, pmap(NO, 3'd1, NO, NO, 3'd1));
    head_check("R11 other inputs not eager", 5, 1, pmap(3'd0, 3'd2, 3'd4, 3'd6, 3'd5));
    chk("R11 explicit", 1'b0, 1'b1, 3'd2);
  endtask

  task automatic t_local();
    head_check("R2 home no eager", 3, 3, {5{NO}});
    chk("R2 explicit", 1'b0, 1'b1, 3'd0);
    head_check("R2 home local eager", 3, 3, pmap(3'd1, NO, NO, NO, NO));
    chk("R2 explicit skip", 1'b0, 1'b0, 3'd0);
    head_check("R2 home only mesh eager", 3, 3, pmap(NO, 3'd1, 3'd1, NO, NO));
  endtask

  task automatic t_body();
    send(1'b1, 1'b0, 5, 1, pmap(NO, 3'd1, NO, NO, NO));
    chk("R10 R5 head of packet", 1'b1, 1'b1, 3'd2);
    send(1'b0, 1'b0, 3, 3, pmap(NO, NO, 3'd1, NO, NO));
    local_x = 3'd5;
    #1;
    chk("R7 body keeps head verdict", 1'b1, 1'b1, 3'd2);
    go_idle();
    chk("R1 gap inside packet", 1'b0, 1'b0, 3'd0);
    send(1'b0, 1'b1, 0, 0, {5{NO}});
    chk("R7 tail keeps head verdict", 1'b1, 1'b1, 3'd2);
    local_x = 3'd3;
    send(1'b0, 1'b0, 5, 1, {5{NO}});
    chk("R8 stray after tail", 1'b1, 1'b0, 3'd0);
  endtask

  task automatic t_single();
    send(1'b1, 1'b0, 3, 6, pmap(NO, 3'd1, NO, NO, NO));
    chk("R4 head north useful", 1'b0, 1'b0, 3'd1);
    send(1'b0, 1'b0, 0, 0, {5{NO}});
    chk("R7 body enq off", 1'b0, 1'b0, 3'd1);
    send(1'b1, 1'b1, 0, 3, {5{NO}});
    chk("R9 single flit", 1'b0, 1'b1, 3'd4);
    send(1'b0, 1'b0, 3, 6, {5{NO}});
    chk("R9 no packet after single", 1'b1, 1'b0, 3'd0);
  endtask

  task automatic t_reset_mid();
    send(1'b1, 1'b0, 3, 6, {5{NO}});
    chk("R6 head before reset", 1'b0, 1'b1, 3'd1);
    @(negedge clk);
    flit_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    send(1'b0, 1'b0, 3, 6, {5{NO}});
    chk("R9 reset closes packet", 1'b1, 1'b0, 3'd0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_idle();
    t_xy_plain();
    t_productive();
    t_dead();
    t_local();
    t_body();
    t_single();
    t_reset_mid();
    go_idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule